// File: doc/BRIEF.md
# Serial Register Port with Full-Word Commit

This block is the slave side of the serial port of a converter controller. A host moves words over a serial clock and one data line in each direction. A separate active-low strobe marks each write frame and each read frame. The address-select pin decides where an access goes. When it is low, the access goes to a 24-bit control register. When it is high, the access goes to the data path. In the coefficient modes the data path reaches a per-channel zero-scale or full-scale calibration coefficient. In every other mode it reaches the conversion result supplied by the converter engine.

Serial traffic is oversampled on the system clock. The block samples input bits on rising serial-clock edges and changes its output bit on falling edges. Bits travel most-significant first. A write takes effect only when its frame closes after exactly 24 serial clocks. Short frames are discarded and clocks beyond the 24th are ignored. The control word is presented continuously to the conversion engine.

Top module: `ser_reg_port`

## Requirements
- R1: After reset the control word output is all zeros and the serial output is low.
- R2: With the address pin low, a write frame of exactly 24 serial clocks loads the control register, MSB first, with input bits taken on rising serial-clock edges. The field layout from bit 23 down is: mode [23:21], gain [20:18], channel [17:16], length bit [15] (1 selects 24-bit data words, 0 selects 16-bit), three option flags [14:12] and rate code [11:0].
- R3: A write frame that closes after fewer than 24 serial clocks (for example 12 or 23) leaves the targeted register unchanged.
- R4: In a write frame with more than 24 serial clocks, the first 24 bits are committed and all later clocks before the strobe rises are ignored.
- R5: With the address pin low, a read frame returns the 24-bit control word MSB first. The first bit is valid once the read strobe is low, and each falling serial-clock edge advances to the next bit.
- R6: With the address pin high in any mode other than 3'b110 and 3'b111, a read returns the conversion result. All 24 bits are returned when the length bit is 1. When it is 0, only the upper 16 bits are returned, followed by zeros.
- R7: In mode 3'b110, data-path accesses read and write the zero-scale coefficient of the channel named by the channel field. A write touches only that channel's entry.
- R8: In mode 3'b111, data-path accesses read and write the full-scale coefficient of the selected channel. This entry is separate from the zero-scale entry of the same channel.
- R9: Coefficient accesses are always 24 bits whatever the length bit. A read with the length bit at 0 returns all 24 bits, and a 16-clock coefficient write is discarded.
- R10: A data-path write in a non-coefficient mode changes neither the control register nor any coefficient.
- R11: The serial output is low whenever no read frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host, idle high |
| sdi | input | 1 | Serial write data, sampled on rising sclk |
| tx_n | input | 1 | Active-low write-frame strobe |
| rx_n | input | 1 | Active-low read-frame strobe |
| addr_hi | input | 1 | Low selects the control register, high selects the data path |
| conv_result | input | 24 | Latest conversion result from the engine |
| sdo | output | 1 | Serial read data, changes on falling sclk |
| ctrl_word | output | 24 | Current control register contents |

## Verification
Assertions watch several properties on every cycle. They check that the write bit counter never passes 24, that clocks after the 24th leave the write shifter frozen, and that the control register and each coefficient entry change only on a commit aimed at them. They also check that a read starts with the loaded word's MSB and that the output stays low between read frames. The bench scenarios are what show that a 12- or 23-clock frame is dropped while a 30-clock frame keeps its first 24 bits. They also show that the 16- versus 24-bit data length does not apply to coefficients, and that channel and mode steer accesses to distinct entries. Only the scenarios reveal full-word content and bit order.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int WORD_W  = 24;
    localparam int SHORT_W = 16;
    localparam int CH_W    = 2;
    localparam int NUM_CH  = 1 << CH_W;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    localparam logic [2:0] MODE_ZERO_COEF = 3'b110;
    localparam logic [2:0] MODE_FULL_COEF = 3'b111;

    typedef struct packed {
        logic [2:0]  mode;
        logic [2:0]  gain;
        logic [1:0]  chan;
        logic        wlen;
        logic [2:0]  flags;
        logic [11:0] rate;
    } ctrl_t;

    typedef enum logic [1:0] {
        TGT_CTRL = 2'd0,
        TGT_DATA = 2'd1,
        TGT_ZERO = 2'd2,
        TGT_FULL = 2'd3
    } target_e;

    function automatic target_e route(input logic addr_hi, input logic [2:0] mode);
        if (!addr_hi)                     return TGT_CTRL;
        else if (mode == MODE_ZERO_COEF)  return TGT_ZERO;
        else if (mode == MODE_FULL_COEF)  return TGT_FULL;
        else                              return TGT_DATA;
    endfunction

    function automatic logic [WORD_W-1:0] data_word(input logic [WORD_W-1:0] res,
                                                    input logic wlen);
        if (wlen) return res;
        return {res[WORD_W-1 -: SHORT_W], {(WORD_W-SHORT_W){1'b0}}};
    endfunction

endpackage

// File: rtl/srp_wr_shifter.sv
module srp_wr_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_start,
    input  logic         frame_end,
    input  logic         bit_strobe,
    input  logic         sdi,
    output logic         commit,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sh  <= '0;
        end else if (frame_start) begin
            cnt <= '0;
        end else if (bit_strobe && cnt != FULL) begin
            sh  <= {sh[W-2:0], sdi};
            cnt <= cnt + 1'b1;
        end
    end

    assign commit = frame_end && (cnt == FULL);
    assign word   = sh;

    p_cnt_cap_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    p_extra_clk_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && !frame_start && cnt == FULL) |=> $stable(sh));

endmodule

// File: rtl/srp_rd_shifter.sv
module srp_rd_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         sdo_bit
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)        sh <= '0;
        else if (load)  sh <= load_word;
        else if (shift) sh <= {sh[W-2:0], 1'b0};
    end

    assign sdo_bit = sh[W-1];

    p_first_bit_msb_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (sdo_bit == $past(load_word[W-1])));

endmodule

// File: rtl/srp_coef_bank.sv
module srp_coef_bank #(
    parameter int W    = 24,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IDXW-1:0] idx,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    rdata
);
    localparam int N = 1 << IDXW;

    logic [W-1:0] ent [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                         ent[g] <= '0;
            else if (we && idx == IDXW'(g))  ent[g] <= wdata;
        end

        p_entry_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !(we && idx == IDXW'(g)) |=> $stable(ent[g]));
    end

    assign rdata = ent[idx];

endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              tx_n,
    input  logic              rx_n,
    input  logic              addr_hi,
    input  logic [WORD_W-1:0] conv_result,
    output logic              sdo,
    output logic [WORD_W-1:0] ctrl_word
);
    logic    sclk_q, tx_q, rx_q;
    ctrl_t   ctrl_q;
    target_e wr_tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b1;
            tx_q   <= 1'b1;
            rx_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            tx_q   <= tx_n;
            rx_q   <= rx_n;
        end
    end

    logic sclk_rise, sclk_fall;
    logic wr_start, wr_end, wr_bit;
    logic rd_start, rd_shift;

    assign sclk_rise = sclk & ~sclk_q;
    assign sclk_fall = ~sclk & sclk_q;
    assign wr_start  = tx_q & ~tx_n;
    assign wr_end    = ~tx_q & tx_n;
    assign wr_bit    = sclk_rise & ~tx_n & ~tx_q;
    assign rd_start  = rx_q & ~rx_n;
    assign rd_shift  = sclk_fall & ~rx_n & ~rx_q;

    // Write path
    logic              commit;
    logic [WORD_W-1:0] wr_word;

    srp_wr_shifter #(.W(WORD_W)) u_wr (
        .clk         (clk),
        .rst         (rst),
        .frame_start (wr_start),
        .frame_end   (wr_end),
        .bit_strobe  (wr_bit),
        .sdi         (sdi),
        .commit      (commit),
        .word        (wr_word)
    );

    always_ff @(posedge clk) begin
        if (rst)           wr_tgt_q <= TGT_CTRL;
        else if (wr_start) wr_tgt_q <= route(addr_hi, ctrl_q.mode);
    end

    always_ff @(posedge clk) begin
        if (rst)                                ctrl_q <= '0;
        else if (commit && wr_tgt_q == TGT_CTRL) ctrl_q <= ctrl_t'(wr_word);
    end

    // Coefficient banks
    logic [WORD_W-1:0] zero_rd, full_rd;
    logic              zero_we, full_we;

    assign zero_we = commit && (wr_tgt_q == TGT_ZERO);
    assign full_we = commit && (wr_tgt_q == TGT_FULL);

    srp_coef_bank #(.W(WORD_W), .IDXW(CH_W)) u_zero (
        .clk   (clk),
        .rst   (rst),
        .we    (zero_we),
        .idx   (ctrl_q.chan),
        .wdata (wr_word),
        .rdata (zero_rd)
    );

    srp_coef_bank #(.W(WORD_W), .IDXW(CH_W)) u_full (
        .clk   (clk),
        .rst   (rst),
        .we    (full_we),
        .idx   (ctrl_q.chan),
        .wdata (wr_word),
        .rdata (full_rd)
    );

    // Read path
    target_e           rd_tgt;
    logic [WORD_W-1:0] rd_word;
    logic              rd_bit;

    always_comb begin
        rd_tgt = route(addr_hi, ctrl_q.mode);
        unique case (rd_tgt)
            TGT_CTRL: rd_word = ctrl_q;
            TGT_ZERO: rd_word = zero_rd;
            TGT_FULL: rd_word = full_rd;
            default:  rd_word = data_word(conv_result, ctrl_q.wlen);
        endcase
    end

    srp_rd_shifter #(.W(WORD_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .load      (rd_start),
        .load_word (rd_word),
        .shift     (rd_shift),
        .sdo_bit   (rd_bit)
    );

    assign sdo       = rd_bit & ~rx_q;
    assign ctrl_word = ctrl_q;

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (ctrl_word == '0));

    p_ctrl_commit_only_r3: assert property (@(posedge clk) disable iff (rst)
        !(commit && wr_tgt_q == TGT_CTRL) |=> $stable(ctrl_word));

    p_data_write_dropped_r10: assert property (@(posedge clk) disable iff (rst)
        (commit && wr_tgt_q == TGT_DATA) |=> $stable(ctrl_word));

    p_idle_sdo_low_r11: assert property (@(posedge clk) disable iff (rst)
        rx_q |-> !sdo);

endmodule

// File: tb/ser_reg_port_bench.sv
module ser_reg_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1, sdi = 1'b0, tx_n = 1'b1, rx_n = 1'b1, addr_hi = 1'b0;
    logic [23:0] conv_result = '0;
    logic        sdo;
    logic [23:0] ctrl_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_reg_port u_ser_reg_port (
        .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .tx_n(tx_n), .rx_n(rx_n),
        .addr_hi(addr_hi), .conv_result(conv_result), .sdo(sdo), .ctrl_word(ctrl_word)
    );

    // {clock count, word sent, expected control word after frame}
    localparam int NV = 5;
    localparam logic [55:0] VEC [NV] = '{
        {8'd24, 24'hA53C0F, 24'hA53C0F},   // R2 full frame
        {8'd12, 24'h123456, 24'hA53C0F},   // R3 12-clock frame dropped
        {8'd30, 24'h5A1234, 24'h5A1234},   // R4 extra clocks ignored
        {8'd24, 24'h008001, 24'h008001},   // R2 length bit set
        {8'd23, 24'hFFFFFF, 24'h008001}    // R3 23-clock frame dropped
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_frame(input logic a, input int nclk, input logic [23:0] w);
        addr_hi = a;
        tx_n = 1'b0;
        tick(2);
        for (int i = 0; i < nclk; i++) begin
            sdi  = (i < 24) ? w[23-i] : 1'b1;
            sclk = 1'b0;
            tick(2);
            sclk = 1'b1;
            tick(2);
        end
        tx_n = 1'b1;
        tick(3);
    endtask

    task automatic read_frame(input logic a, output logic [23:0] w);
        addr_hi = a;
        w = '0;
        rx_n = 1'b0;
        tick(2);
        w = {w[22:0], sdo};
        for (int i = 1; i < 24; i++) begin
            sclk = 1'b0;
            tick(2);
            sclk = 1'b1;
            tick(2);
            w = {w[22:0], sdo};
        end
        rx_n = 1'b1;
        tick(2);
    endtask

    initial begin
        logic [23:0] rd;
        tick(3);
        rst = 1'b0;
        tick(2);
        check("R1 ctrl after reset", ctrl_word, 24'h0);
        check("R1 sdo after reset", {23'b0, sdo}, 24'h0);

        for (int v = 0; v < NV; v++) begin
            write_frame(1'b0, int'(VEC[v][55:48]), VEC[v][47:24]);
            check("R2/R3/R4 ctrl after write", ctrl_word, VEC[v][23:0]);
            read_frame(1'b0, rd);
            check("R5 ctrl readback", rd, VEC[v][23:0]);
            check("R11 sdo idle", {23'b0, sdo}, 24'h0);
        end

        // R6 data register, 24-bit then 16-bit length
        conv_result = 24'hC3A596;
        read_frame(1'b1, rd);
        check("R6 data 24-bit", rd, 24'hC3A596);
        write_frame(1'b0, 24, 24'h000001);
        read_frame(1'b1, rd);
        check("R6 data 16-bit", rd, 24'hC3A500);

        // R7 / R9 zero-scale coefficient, length bit 0
        write_frame(1'b0, 24, 24'hC20000);
        write_frame(1'b1, 24, 24'hABCDEF);
        read_frame(1'b1, rd);
        check("R7 R9 zero coef ch2", rd, 24'hABCDEF);
        write_frame(1'b1, 16, 24'h111111);
        read_frame(1'b1, rd);
        check("R9 16-clock coef write dropped", rd, 24'hABCDEF);
        write_frame(1'b0, 24, 24'hC10000);
        read_frame(1'b1, rd);
        check("R7 other channel untouched", rd, 24'h000000);

        // R8 full-scale coefficient
        write_frame(1'b0, 24, 24'hE20000);
        write_frame(1'b1, 24, 24'h654321);
        read_frame(1'b1, rd);
        check("R8 full coef ch2", rd, 24'h654321);
        write_frame(1'b0, 24, 24'hC20000);
        read_frame(1'b1, rd);
        check("R8 zero coef separate", rd, 24'hABCDEF);

        // R10 data-path write in normal mode is dropped
        write_frame(1'b0, 24, 24'h020000);
        write_frame(1'b1, 24, 24'h999999);
        check("R10 ctrl unchanged", ctrl_word, 24'h020000);
        write_frame(1'b0, 24, 24'hC20000);
        read_frame(1'b1, rd);
        check("R10 zero coef unchanged", rd, 24'hABCDEF);
        write_frame(1'b0, 24, 24'hE20000);
        read_frame(1'b1, rd);
        check("R10 full coef unchanged", rd, 24'h654321);
        check("R11 sdo idle at end", {23'b0, sdo}, 24'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule